// File: doc/BRIEF.md
# Character Sync Hunt Receiver

This block is the receive front end of a character-oriented synchronous serial link. Each time the bit strobe is high it takes one serial bit. Until it locks, it keeps looking for a programmed sync pattern in the incoming bits. After it locks, it splits the bit stream into fixed-width characters and reports each one with a single-cycle valid pulse.

There are two hunt modes. In single mode, the newest eight bits only have to equal the second sync character. In dual mode, two characters in a row must match: an older eight-bit group, held in the character shift register, must equal the first sync character, and the newest eight-bit group, held in the sync assembly register, must equal the second. The window slides forward by one bit on every accepted bit.

Once locked, bits no longer pass through the sync assembly register. They go through a fixed three-bit delay into the character shift register. Lock lasts until an enter-hunt command clears it and starts a new search.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `locked`, `char_valid` and `char_out` are all zero.
- R2: Bits shift in at the least significant end. In a delivered character, the earliest received bit is bit 7 and the latest is bit 0.
- R3: In single mode (`dual_mode`=0), `locked` rises at the clock edge that accepts a bit when the last eight accepted bits equal `sync_b`. The comparison is made on every accepted bit, not only on eight-bit boundaries.
- R4: In dual mode (`dual_mode`=1), `locked` rises only when the older eight bits of the last sixteen accepted bits equal `sync_a` and the newer eight equal `sync_b`.
- R5: No lock is declared until at least 8 bits (single mode) or 16 bits (dual mode) have been accepted since reset or the last enter-hunt command.
- R6: A cycle with `bit_en` low and `hunt` low changes neither `locked` nor `char_out`, and raises no `char_valid`.
- R7: After lock, the first character is made of the eight bits that follow the sync pattern. Because of the three-bit delay, `char_valid` is high in the cycle after the 11th accepted bit past the pattern. It then pulses again after every further 8 accepted bits.
- R8: `char_out` holds the last delivered character until the next `char_valid`. Sync pattern bits are never delivered as data.
- R9: `hunt` high clears `locked` and the bit counters and restarts the search. It takes priority over a bit accepted in the same cycle, and that bit is discarded.
- R10: `locked` stays high whatever data arrives, until `hunt` is asserted.
- R11: `char_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial data bit |
| bit_en | input | 1 | Strobe: take `rx_bit` in this cycle |
| dual_mode | input | 1 | 0 selects single-character hunt, 1 selects two-character hunt |
| sync_a | input | 8 | First sync character (dual mode only) |
| sync_b | input | 8 | Second sync character (both modes) |
| hunt | input | 1 | Enter-hunt command |
| locked | output | 1 | Sync acquired |
| char_out | output | 8 | Last received character |
| char_valid | output | 1 | One-cycle pulse when a new character is in `char_out` |

## Verification
The assertions assume that `dual_mode`, `sync_a` and `sync_b` stay constant while a search is in progress, and that `hunt` is a short command rather than a held level. The stimulus sets the mode and patterns only while no bits are being sent and just before an enter-hunt pulse. It keeps them fixed for the whole stream that follows, and it raises `hunt` for a single cycle at a time, sometimes together with a bit strobe. Idle cycles of random length, with random values on `rx_bit`, separate the strobed bits. This exercises the rule that data without a strobe is ignored, without ever breaking the stability assumptions.

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
  parameter int CW  = 8,
  parameter int DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit,
  input  logic          bit_en,
  input  logic          dual_mode,
  input  logic [CW-1:0] sync_a,
  input  logic [CW-1:0] sync_b,
  input  logic          hunt,
  output logic          locked,
  output logic [CW-1:0] char_out,
  output logic          char_valid
);

  localparam int FW = $clog2(2*CW + 1);
  localparam int NW = (CW > 1) ? $clog2(CW) : 1;
  localparam int PW = $clog2(DLY + 1);
  localparam logic [FW-1:0] FULL = FW'(2*CW);
  localparam logic [NW-1:0] LAST = NW'(CW - 1);
  localparam logic [PW-1:0] PRIMED = PW'(DLY);

  logic [CW-1:0]  sync_sr, rsr, char_q;
  logic [DLY-1:0] dly;
  logic [FW-1:0]  fill;
  logic [PW-1:0]  prime;
  logic [NW-1:0]  cnt;
  logic           locked_q, valid_q;

  logic [CW-1:0]  sr_nx, rsr_hunt_nx, rsr_run_nx;
  logic [DLY:0]   dly_ext;
  logic [FW-1:0]  fill_nx, need;
  logic           match, hit;

  assign sr_nx       = {sync_sr[CW-2:0], rx_bit};
  assign rsr_hunt_nx = {rsr[CW-2:0], sync_sr[CW-1]};
  assign dly_ext     = {dly, rx_bit};
  assign rsr_run_nx  = {rsr[CW-2:0], dly_ext[DLY]};
  assign fill_nx     = (fill == FULL) ? fill : fill + 1'b1;
  assign need        = dual_mode ? FULL : FW'(CW);
  assign match       = dual_mode ? (rsr_hunt_nx == sync_a && sr_nx == sync_b)
                                 : (sr_nx == sync_b);
  assign hit         = !locked_q && bit_en && (fill_nx >= need) && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_sr  <= '0;
      rsr      <= '0;
      char_q   <= '0;
      dly      <= '0;
      fill     <= '0;
      prime    <= '0;
      cnt      <= '0;
      locked_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (hunt) begin
        sync_sr  <= '0;
        rsr      <= '0;
        dly      <= '0;
        fill     <= '0;
        prime    <= '0;
        cnt      <= '0;
        locked_q <= 1'b0;
      end else if (bit_en) begin
        if (!locked_q) begin
          sync_sr <= sr_nx;
          rsr     <= rsr_hunt_nx;
          fill    <= fill_nx;
          if (hit) begin
            locked_q <= 1'b1;
            dly      <= '0;
            prime    <= '0;
            cnt      <= '0;
          end
        end else begin
          dly <= dly_ext[DLY-1:0];
          rsr <= rsr_run_nx;
          if (prime != PRIMED) begin
            prime <= prime + 1'b1;
          end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) begin
              valid_q <= 1'b1;
              char_q  <= rsr_run_nx;
            end
          end
        end
      end
    end
  end

  assign locked     = locked_q;
  assign char_out   = char_q;
  assign char_valid = valid_q;

  a_r5_fill_guard: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(fill) >= FW'(CW - 1)));
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !hunt) |=> ($stable(locked) && !char_valid));
  a_r7_no_char_at_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !char_valid);
  a_r7_char_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> locked);
  a_r8_char_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |-> $stable(char_out));
  a_r9_hunt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hunt |=> (!locked && !char_valid));
  a_r10_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !hunt) |=> locked);
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);

endmodule

// File: tb/sync_hunt_rx_tb.sv
module sync_hunt_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0, bit_en = 1'b0, dual_mode = 1'b0, hunt = 1'b0;
  logic [7:0] sync_a = '0, sync_b = '0;
  logic       locked, char_valid;
  logic [7:0] char_out;

  int n_chk = 0, n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] hist;
  logic [15:0] dhist;
  int          m_cnt, m_k;
  logic        m_lock;
  logic [7:0]  last_char;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  sync_hunt_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_en(bit_en),
    .dual_mode(dual_mode), .sync_a(sync_a), .sync_b(sync_b), .hunt(hunt),
    .locked(locked), .char_out(char_out), .char_valid(char_valid)
  );

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    hist = '0; dhist = '0; m_cnt = 0; m_k = 0; m_lock = 1'b0;
  endtask

  task automatic do_hunt(input logic with_bit);
    @(negedge clk);
    hunt = 1'b1; bit_en = with_bit; rx_bit = rnd();
    @(negedge clk);
    hunt = 1'b0; bit_en = 1'b0;
    model_clear();
    check(locked == 1'b0, "R9 lock after hunt", locked, 0);
    check(char_valid == 1'b0, "R9 valid after hunt", char_valid, 0);
  endtask

  task automatic step(input logic b, input int idle);
    logic       expv;
    logic [7:0] expc;
    string      ltag;
    expv = 1'b0; expc = '0;
    @(negedge clk);
    rx_bit = b; bit_en = 1'b1;
    ltag = m_lock ? "R10" : (dual_mode ? "R4" : "R3");
    if (!m_lock) begin
      hist = {hist[14:0], b};
      if (m_cnt < 16) m_cnt++;
      if (m_cnt >= (dual_mode ? 16 : 8) &&
          hist[7:0] == sync_b && (!dual_mode || hist[15:8] == sync_a)) begin
        m_lock = 1'b1; m_k = 0; dhist = '0;
      end
    end else begin
      m_k++;
      dhist = {dhist[14:0], b};
      if (m_k >= 11 && ((m_k - 11) % 8) == 0) begin
        expv = 1'b1; expc = dhist[10:3];
      end
    end
    @(negedge clk);
    bit_en = 1'b0;
    check(locked == m_lock, ltag, locked, m_lock);
    check(char_valid == expv, "R7 valid timing", char_valid, expv);
    if (expv) begin
      check(char_out == expc, "R2 char value", char_out, expc);
      last_char = expc;
    end
    for (int i = 0; i < idle; i++) begin
      rx_bit = rnd();
      @(negedge clk);
      check(char_valid == 1'b0, (i == 0 && expv) ? "R11 pulse" : "R6 idle valid", char_valid, 0);
      check(locked == m_lock, "R6 idle lock", locked, m_lock);
      check(char_out == last_char, "R8 hold", char_out, last_char);
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int j = 7; j >= 0; j--) step(v[j], int'({rnd(), rnd()}) % 3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    last_char = '0;
    repeat (3) @(negedge clk);
    check(locked == 1'b0, "R1 locked", locked, 0);
    check(char_valid == 1'b0, "R1 valid", char_valid, 0);
    check(char_out == 8'h00, "R1 char", char_out, 0);
    rst_n = 1'b1;

    // R5: all-zero pattern locks exactly at bit 8 (single) and bit 16 (dual)
    sync_b = 8'h00; dual_mode = 1'b0;
    do_hunt(1'b0);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 0);
      check(locked == (i == 7), "R5 single fill", locked, i == 7);
    end
    sync_a = 8'h00; dual_mode = 1'b1;
    do_hunt(1'b0);
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1);
      check(locked == (i == 15), "R5 dual fill", locked, i == 15);
    end

    // R3: sweep every single-mode pattern
    dual_mode = 1'b0;
    for (int p = 0; p < 256; p++) begin
      sync_b = 8'(p);
      do_hunt(p[0]);
      for (int j = 0; j < 3; j++) step(rnd(), 0);
      send_byte(8'(p));
      check(locked == 1'b1, "R3 sweep lock", locked, 1);
      send_byte(8'(p) ^ 8'h5A);
      send_byte(~8'(p));
      send_byte(8'(p * 7));
    end

    // R4: sweep dual-mode pattern pairs
    dual_mode = 1'b1;
    for (int p = 0; p < 256; p++) begin
      sync_a = 8'(p); sync_b = 8'(p * 37 + 11);
      do_hunt(1'b1);
      for (int j = 0; j < 5; j++) step(rnd(), 0);
      send_byte(sync_b);
      send_byte(sync_a);
      send_byte(sync_b);
      check(locked == 1'b1, "R4 sweep lock", locked, 1);
      send_byte(8'(p) ^ 8'hC3);
      send_byte(8'(p + 1));
      for (int j = 0; j < 4; j++) step(rnd(), 1);
    end

    // R9: hunt in the middle of data drops lock; relock follows
    dual_mode = 1'b0; sync_b = 8'h7E;
    do_hunt(1'b0);
    send_byte(8'h7E);
    send_byte(8'h12);
    do_hunt(1'b1);
    check(locked == 1'b0, "R9 midstream", locked, 0);
    send_byte(8'h7E);
    send_byte(8'h34);
    send_byte(8'h56);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule